// File: doc/BRIEF.md
# Flash Status Pin Mode Controller

This block produces the active-low, open-drain style ready/status indication of a parallel NOR flash command interface. It watches the busy flag of the internal write state machine together with single-cycle erase-done and program-done events. A configuration command selects how the pin signals. In level mode the pin simply tracks busy versus ready. In one of three pulse modes it emits a fixed-width low pulse when the selected kinds of operation complete.

A configuration command carries its 2-bit mode code in the lowest data bits, and all higher data bits are ignored. The command is refused while the write state machine is busy or suspended. A code that the build does not support is also refused. Either refusal sets both error flags in the status byte, and a clear-status strobe resets them. Completions that belong to lock-bit operations never produce a pulse. The pulse width is fixed in clock cycles and is derived at elaboration time from a nominal 500 ns and the clock period.

Top module: `stspin_ctrl`

## Requirements
- R1: After reset the mode is 00 (level), `sts_no` is 1 and `status_o` is 8'h80.
- R2: In mode 00, `sts_no` equals the inverse of `wsm_busy_i` as sampled at the previous clock edge.
- R3: A configuration strobe that arrives while the device is neither busy nor suspended, and whose code `cfg_data_i[1:0]` is supported, sets `mode_o` to that code on the next cycle. Data bits above bit 1 have no effect.
- R4: A configuration strobe that arrives while `wsm_busy_i` or `wsm_susp_i` is high leaves `mode_o` unchanged and sets `status_o[5]` and `status_o[4]` on the next cycle.
- R5: A code whose bit in parameter `MODE_MASK` is 0 is refused. `mode_o` stays unchanged and `status_o[5:4]` becomes 2'b11.
- R6: In modes 01 and 11, an `erase_done_i` strobe drives `sts_no` low from the next cycle on, for exactly `PULSE_CYC` cycles.
- R7: In modes 10 and 11, a `prog_done_i` strobe drives `sts_no` low from the next cycle on, for exactly `PULSE_CYC` cycles.
- R8: In a pulse mode, `sts_no` ignores `wsm_busy_i`. A completion event that the mode does not select produces no pulse.
- R9: An event that arrives with `lock_op_i` high never produces a pulse, in any mode.
- R10: A selected event that arrives during an active pulse restarts the pulse, which then lasts `PULSE_CYC` cycles from the new event.
- R11: `status_o[7]` is 1 when the registered busy flag is 0. `clr_stat_i` clears `status_o[5:4]` on the next cycle, and a refusal in the same cycle takes priority over the clear. All other status bits are 0.
- R12: `PULSE_CYC` equals ceil(PULSE_NS*1000/CLK_PS), which is 125 cycles at the default 500 ns and 4 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration command strobe |
| cfg_data_i | input | DATA_W | Command data; bits [1:0] hold the mode code |
| clr_stat_i | input | 1 | Clears the status error flags |
| wsm_busy_i | input | 1 | Write state machine busy |
| wsm_susp_i | input | 1 | Write state machine suspended |
| erase_done_i | input | 1 | Single-cycle erase completion event |
| prog_done_i | input | 1 | Single-cycle program completion event |
| lock_op_i | input | 1 | The current completion event belongs to a lock-bit operation |
| sts_no | output | 1 | Active-low status pin |
| mode_o | output | 2 | Current signalling mode |
| status_o | output | 8 | Status byte: [7] ready, [5:4] error flags |

## Verification
The bound assertions check several rules on every clock. They check level-mode tracking of busy, the acceptance and refusal of configuration commands with their effect on the error flags, the start of a pulse after a selected event, the suppression of pulses for lock operations, and the ready bit. The pulse width and its restart by a late event span more than a hundred cycles, so only the bench's scenarios show them. The same holds for the silence of unselected events and for a build that supports only some codes. For these cases the bench counts the low cycles of the pin and also compares against its reference model on every clock.

// File: rtl/stspin_pkg.sv
package stspin_pkg;

   typedef enum logic [1:0] {
      SIG_LEVEL  = 2'b00,
      SIG_ERASE  = 2'b01,
      SIG_PROG   = 2'b10,
      SIG_EITHER = 2'b11
   } sig_mode_e;

   localparam int unsigned N_EVT = 2;   // bit 0 erase, bit 1 program

   function automatic logic code_supported(input logic [3:0] mask, input logic [1:0] code);
      return mask[code];
   endfunction

   function automatic int unsigned cycles_for_ns(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/stspin_cfg.sv
module stspin_cfg
   import stspin_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter logic [3:0]  MODE_MASK = 4'b1111
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              busy_i,
   input  logic              susp_i,
   output sig_mode_e         mode_o,
   output logic              accept_o,
   output logic              reject_o
);

   logic [1:0] code;
   logic       idle;
   logic       legal;
   sig_mode_e  mode_q;

   assign code  = data_i[1:0];
   assign idle  = !busy_i && !susp_i;
   assign legal = code_supported(MODE_MASK, code);

   assign accept_o = we_i && idle && legal;
   assign reject_o = we_i && !(idle && legal);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= SIG_LEVEL;
      end else if (accept_o) begin
         mode_q <= sig_mode_e'(code);
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/stspin_pulse.sv
module stspin_pulse #(
   parameter int unsigned PULSE_CYC = 125,
   localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   input  logic clear_i,
   output logic active_o
);

   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (fire_i) begin
         cnt_q <= RELOAD;            // restart, so a late event is not lost
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

endmodule

// File: rtl/stspin_stat.sv
module stspin_stat (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       busy_i,
   input  logic       err_set_i,
   input  logic       err_clr_i,
   output logic       busy_q_o,
   output logic [7:0] status_o
);

   localparam int unsigned N_ERR = 2;   // command error and sequence error flags

   logic             busy_q;
   logic [N_ERR-1:0] err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
      end else begin
         busy_q <= busy_i;
      end
   end

   for (genvar g = 0; g < N_ERR; g++) begin : g_err
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            err_q[g] <= 1'b0;
         end else if (err_set_i) begin
            err_q[g] <= 1'b1;
         end else if (err_clr_i) begin
            err_q[g] <= 1'b0;
         end
      end
   end

   assign busy_q_o = busy_q;
   assign status_o = {~busy_q, 1'b0, err_q[1], err_q[0], 4'b0000};

endmodule

// File: rtl/stspin_ctrl.sv
module stspin_ctrl
   import stspin_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter logic [3:0]  MODE_MASK = 4'b1111,
   parameter int unsigned CLK_PS    = 4000,
   parameter int unsigned PULSE_NS  = 500
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [DATA_W-1:0] cfg_data_i,
   input  logic              clr_stat_i,
   input  logic              wsm_busy_i,
   input  logic              wsm_susp_i,
   input  logic              erase_done_i,
   input  logic              prog_done_i,
   input  logic              lock_op_i,
   output logic              sts_no,
   output logic [1:0]        mode_o,
   output logic [7:0]        status_o
);

   localparam int unsigned PULSE_CYC = cycles_for_ns(PULSE_NS, CLK_PS);

   if (DATA_W < 2) begin : g_bad_width
      $error("stspin_ctrl: DATA_W must hold a 2-bit mode code");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("stspin_ctrl: pulse width rounds to zero cycles");
   end
   if (!MODE_MASK[0]) begin : g_bad_mask
      $error("stspin_ctrl: level mode is the reset mode and must be supported");
   end

   sig_mode_e          mode;
   logic               accept;
   logic               reject;
   logic               busy_q;
   logic               active;
   logic [N_EVT-1:0]   evt;
   logic [N_EVT-1:0]   evt_sel;
   logic               fire;

   stspin_cfg #(
      .DATA_W   (DATA_W),
      .MODE_MASK(MODE_MASK)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .data_i  (cfg_data_i),
      .busy_i  (wsm_busy_i),
      .susp_i  (wsm_susp_i),
      .mode_o  (mode),
      .accept_o(accept),
      .reject_o(reject)
   );

   // Mode bit i enables completion source i; lock operations never qualify.
   assign evt = {prog_done_i, erase_done_i};
   for (genvar g = 0; g < N_EVT; g++) begin : g_evt
      assign evt_sel[g] = evt[g] && mode[g] && !lock_op_i;
   end
   assign fire = |evt_sel;

   stspin_pulse #(
      .PULSE_CYC(PULSE_CYC)
   ) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire),
      .clear_i (accept),
      .active_o(active)
   );

   stspin_stat u_stat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .busy_i   (wsm_busy_i),
      .err_set_i(reject),
      .err_clr_i(clr_stat_i),
      .busy_q_o (busy_q),
      .status_o (status_o)
   );

   assign sts_no = (mode == SIG_LEVEL) ? ~busy_q : ~active;
   assign mode_o = mode;

endmodule

// File: rtl/stspin_ctrl_chk.sv
module stspin_ctrl_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter logic [3:0]  MODE_MASK = 4'b1111
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cfg_we_i,
   input logic [DATA_W-1:0] cfg_data_i,
   input logic              clr_stat_i,
   input logic              wsm_busy_i,
   input logic              wsm_susp_i,
   input logic              erase_done_i,
   input logic              prog_done_i,
   input logic              lock_op_i,
   input logic              sts_no,
   input logic [1:0]        mode_o,
   input logic [7:0]        status_o
);

   logic past_ok;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   assert_level_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && mode_o == 2'b00) |-> (sts_no == !$past(wsm_busy_i)));

   assert_cfg_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && !wsm_busy_i && !wsm_susp_i && MODE_MASK[cfg_data_i[1:0]])
      |=> (mode_o == $past(cfg_data_i[1:0])));

   assert_busy_refuse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && (wsm_busy_i || wsm_susp_i)) |=> ($stable(mode_o) && status_o[5:4] == 2'b11));

   assert_bad_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && !MODE_MASK[cfg_data_i[1:0]]) |=> ($stable(mode_o) && status_o[5:4] == 2'b11));

   assert_erase_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o[0] && erase_done_i && !lock_op_i && !cfg_we_i) |=> !sts_no);

   assert_prog_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o[1] && prog_done_i && !lock_op_i && !cfg_we_i) |=> !sts_no);

   assert_lock_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o != 2'b00 && sts_no && lock_op_i && !cfg_we_i) |=> sts_no);

   assert_ready_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (status_o[7] == !$past(wsm_busy_i) && status_o[6] == 1'b0 && status_o[3:0] == 4'h0));

   assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_stat_i && !cfg_we_i) |=> (status_o[5:4] == 2'b00));

endmodule

bind stspin_ctrl stspin_ctrl_chk #(.DATA_W(DATA_W), .MODE_MASK(MODE_MASK)) chk_i (.*);

// File: tb/stspin_ctrl_tb_top.sv
`timescale 1ns/1ps
module stspin_ctrl_tb_top;

   localparam int unsigned DW     = 16;
   localparam logic [3:0]  MASK_R = 4'b0111;
   localparam int          EXP_W  = (500 * 1000 + 4000 - 1) / 4000;   // R12

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [DW-1:0] cfg_data = '0;
   logic          clr_stat = 1'b0;
   logic          busy = 1'b0;
   logic          susp = 1'b0;
   logic          erase_done = 1'b0;
   logic          prog_done = 1'b0;
   logic          lock_op = 1'b0;

   logic          sts_i, sts_r;
   logic [1:0]    mode_i, mode_r;
   logic [7:0]    stat_i, stat_r;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   stspin_ctrl #(.DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
      .clr_stat_i(clr_stat), .wsm_busy_i(busy), .wsm_susp_i(susp),
      .erase_done_i(erase_done), .prog_done_i(prog_done), .lock_op_i(lock_op),
      .sts_no(sts_i), .mode_o(mode_i), .status_o(stat_i)
   );

   stspin_ctrl #(.DATA_W(DW), .MODE_MASK(MASK_R)) dut_r (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
      .clr_stat_i(clr_stat), .wsm_busy_i(busy), .wsm_susp_i(susp),
      .erase_done_i(erase_done), .prog_done_i(prog_done), .lock_op_i(lock_op),
      .sts_no(sts_r), .mode_o(mode_r), .status_o(stat_r)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference model, updated at every rising edge.
   int      m_mode[2];
   int      m_cnt[2];
   bit [1:0] m_err[2];
   bit      m_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_mode[k] = 0; m_cnt[k] = 0; m_err[k] = 2'b00;
         end
         m_busy = 1'b0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            logic [3:0] mask;
            int  code;
            bit  acc, rej, fire;
            mask = (k == 0) ? 4'b1111 : MASK_R;
            code = int'(cfg_data[1:0]);
            acc  = cfg_we && !busy && !susp && mask[code];
            rej  = cfg_we && !acc;
            fire = !lock_op && ((erase_done && m_mode[k][0]) || (prog_done && m_mode[k][1]));
            if (acc)           m_cnt[k] = 0;
            else if (fire)     m_cnt[k] = EXP_W;
            else if (m_cnt[k] > 0) m_cnt[k]--;
            if (rej)           m_err[k] = 2'b11;
            else if (clr_stat) m_err[k] = 2'b00;
            if (acc)           m_mode[k] = code;
         end
         m_busy = busy;
      end
   end

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int k = 0; k < 2; k++) begin
            logic       s;
            logic [1:0] md;
            logic [7:0] st;
            logic       exp_s;
            s  = (k == 0) ? sts_i  : sts_r;
            md = (k == 0) ? mode_i : mode_r;
            st = (k == 0) ? stat_i : stat_r;
            exp_s = (m_mode[k] == 0) ? !m_busy : (m_cnt[k] == 0);
            chk((m_mode[k] == 0) ? "R2 model sts" : "R6/R7 model sts", 32'(s), 32'(exp_s));
            chk("R3 model mode", 32'(md), 32'(m_mode[k]));
            chk("R11 model status", 32'(st), {24'd0, !m_busy, 1'b0, m_err[k], 4'b0000});
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic cfg(input logic [DW-1:0] d);
      cfg_we = 1'b1; cfg_data = d;
      cyc(1);
      cfg_we = 1'b0; cfg_data = '0;
   endtask

   task automatic clear_err();
      clr_stat = 1'b1; cyc(1); clr_stat = 1'b0;
   endtask

   // Inject an event, count low cycles of dut_i's pin; optionally retrigger with a program event.
   task automatic fire(input bit e, input bit p, input bit l, input int win,
                       input int retrig_at, output int lows);
      erase_done = e; prog_done = p; lock_op = l;
      lows = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (!sts_i) lows++;
         #1;
         erase_done = 1'b0; prog_done = 1'b0; lock_op = 1'b0;
         if (i == retrig_at) prog_done = 1'b1;
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int lows;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 reset sts", 32'(sts_i), 32'd1);
      chk("R1 reset mode", 32'(mode_i), 32'd0);
      chk("R1 reset status", 32'(stat_i), 32'h80);

      busy = 1'b1; cyc(1);
      chk("R2 busy drives pin low", 32'(sts_i), 32'd0);

      cfg(16'h0001);
      chk("R4 refused while busy mode", 32'(mode_i), 32'd0);
      chk("R4 refused while busy status", 32'(stat_i), 32'h30);

      clear_err();
      chk("R11 clear error flags", 32'(stat_i), 32'h00);
      busy = 1'b0; cyc(1);
      chk("R11 ready bit", 32'(stat_i), 32'h80);
      chk("R2 ready releases pin", 32'(sts_i), 32'd1);

      susp = 1'b1;
      cfg(16'h0002);
      susp = 1'b0;
      chk("R4 refused while suspended mode", 32'(mode_i), 32'd0);
      chk("R4 refused while suspended status", 32'(stat_i), 32'hB0);
      clear_err();

      cfg(16'hFFFD);
      chk("R3 upper bits ignored", 32'(mode_i), 32'd1);
      chk("R3 restricted build accepts 01", 32'(mode_r), 32'd1);

      busy = 1'b1; cyc(2);
      chk("R8 pulse mode ignores busy", 32'(sts_i), 32'd1);
      busy = 1'b0; cyc(1);

      fire(1'b1, 1'b0, 1'b0, EXP_W + 20, -1, lows);
      chk("R6 R12 erase pulse width", 32'(lows), 32'(EXP_W));
      fire(1'b0, 1'b1, 1'b0, 20, -1, lows);
      chk("R8 program unselected in mode 01", 32'(lows), 32'd0);

      cfg(16'h0002);
      chk("R3 mode 10", 32'(mode_i), 32'd2);
      fire(1'b0, 1'b1, 1'b0, EXP_W + 20, -1, lows);
      chk("R7 program pulse width", 32'(lows), 32'(EXP_W));
      fire(1'b1, 1'b0, 1'b0, 20, -1, lows);
      chk("R8 erase unselected in mode 10", 32'(lows), 32'd0);
      fire(1'b0, 1'b1, 1'b1, 20, -1, lows);
      chk("R9 lock completion no pulse", 32'(lows), 32'd0);

      cfg(16'h0003);
      chk("R3 mode 11", 32'(mode_i), 32'd3);
      chk("R5 unsupported code mode kept", 32'(mode_r), 32'd2);
      chk("R5 unsupported code flags", 32'(stat_r), 32'hB0);
      clear_err();

      fire(1'b1, 1'b0, 1'b1, 20, -1, lows);
      chk("R9 lock erase no pulse in 11", 32'(lows), 32'd0);
      fire(1'b1, 1'b0, 1'b0, EXP_W + 20, -1, lows);
      chk("R6 erase pulse in 11", 32'(lows), 32'(EXP_W));
      // Retrigger set after sample 50, reloads one edge later: lows = 51 + width.
      fire(1'b1, 1'b0, 1'b0, EXP_W + 100, 50, lows);
      chk("R10 retrigger extends pulse", 32'(lows), 32'(51 + EXP_W));

      cfg(16'h0000);
      chk("R3 back to level", 32'(mode_i), 32'd0);
      busy = 1'b1; cyc(1);
      chk("R2 level after return", 32'(sts_i), 32'd0);
      busy = 1'b0; cyc(2);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule